// File: doc/BRIEF.md
# Flash Read Response Multiplexer

This block forms the read data of a parallel flash that sits on a 32-bit bus and is built from two 16-bit devices placed side by side. A separate command controller decides which of four read views is active. In the memory view, the block takes the 64-bit aligned word that the storage presents for the current address and picks out the byte lanes that the access size and the low address bits select. In the three other views it forms a single 16-bit value and copies it into both 16-bit halves of a 32-bit access, the way two identical devices would both answer. Those views are the status byte, the identification words and the self-description query table.

The query table is a small fixed ROM. Its geometry entries are not stored. They are derived from the parameters for the total size and the erase block size. These entries are the device size code, the erase block count and the per-device block size. The identification view also reports the lock state of one erase block, taken from a lock bitmap that another block maintains.

Every accepted read strobe produces registered read data one clock later, together with a valid pulse.

Top module: `flash_read_mux`

## Requirements
- R1: While reset is asserted and after it is released, `rd_valid` is 0 and `rd_data` is 0 until the first read strobe.
- R2: A read with `rd_en` high in one cycle gives `rd_valid` high and the new `rd_data` in the next cycle only. Without a strobe, `rd_valid` is 0 and `rd_data` keeps its value.
- R3: Memory view (`rd_mode`=0). `array_word` holds the bytes at addresses (A & ~7) to (A | 7), with byte k in bits [8k+7:8k]. A 1-byte read returns lane A[2:0]. A 2-byte read returns the lanes starting at 2*A[2:1]. A 4-byte read returns the lanes starting at 4*A[2]. An 8-byte read returns the whole word. Bits above the access size are 0.
- R4: Status view (`rd_mode`=1). The 16-bit value is `status_reg` zero-extended.
- R5: Identification view (`rd_mode`=2). The word index is A[10:2]. Index 0 gives 0x0000 and index 1 gives 0xFFFF. Every index from 3 up gives 0, and address bits 11 and above do not change these results.
- R6: Identification index 2 returns 1 when bit (A >> BLK_LOG2) of `lock_map` is set, and 0 when it is clear.
- R7: Query view (`rd_mode`=3). The table index is A >> 2, and the value is that entry zero-extended. Entries 0x10..0x12 hold 0x51, 0x52, 0x59. Entry 0x13 holds 0x01 and entry 0x15 holds 0x31. Entries 0x31..0x33 hold 0x50, 0x52, 0x49.
- R8: Entry 0x27 is FLASH_LOG2-1. Entries 0x2D/0x2E hold the erase block count minus one, as low byte then high byte. Entries 0x2F/0x30 hold 2^(BLK_LOG2-1)/256, as low byte then high byte. With the defaults these are 0x13, 0x0F, 0x00, 0x80 and 0x00.
- R9: A query index of 0x44 or above returns 0.
- R10: In views 1 to 3, `rd_size` selects the format of the 16-bit value v. Size 0 (1 byte) gives v[7:0]. Size 1 (2 bytes) gives v. Size 2 (4 bytes) gives {v,v}. Size 3 (8 bytes) gives {32'h0,v,v}. All bits above these are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | FLASH_LOG2 | Byte address of the read |
| rd_size | input | 2 | Access size: 0=1, 1=2, 2=4, 3=8 bytes |
| rd_mode | input | 2 | Read view: 0 memory, 1 status, 2 identification, 3 query |
| status_reg | input | 8 | Current status byte |
| lock_map | input | 2^(FLASH_LOG2-BLK_LOG2) | One lock bit per erase block |
| array_word | input | 64 | Aligned storage word at the read address |
| rd_data | output | 64 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after the strobe |

## Verification
The bench aims at lane selection inside the memory word. A design that ignored the low address bits, or that shifted by the wrong unit, would return a neighbouring byte pair. It reads the identification words above the 2 KB mask, so that a design that failed to mask the high address bits would return 0 for the vendor and device words. It locks one block and reads the lock word in that block and in its neighbour, which catches an off-by-one in the block index. It reads the query geometry entries and the first index past the table, catching a wrong size code, a swapped byte order or a table that wraps. It checks that 4-byte reads mirror the value and that 8-byte reads leave the upper half clear, so a missing copy or stray upper bits show up as a mismatch.

// File: rtl/flash_read_mux.sv
module flash_read_mux #(
  parameter int FLASH_LOG2 = 20,
  parameter int BLK_LOG2   = 16,
  parameter int PBUF_LOG2  = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_en,
  input  logic [FLASH_LOG2-1:0]  rd_addr,
  input  logic [1:0]             rd_size,
  input  logic [1:0]             rd_mode,
  input  logic [7:0]             status_reg,
  input  logic [(1<<(FLASH_LOG2-BLK_LOG2))-1:0] lock_map,
  input  logic [63:0]            array_word,
  output logic [63:0]            rd_data,
  output logic                   rd_valid
);
  localparam int NBLK     = 1 << (FLASH_LOG2 - BLK_LOG2);
  localparam int QI_W     = FLASH_LOG2 - 2;
  localparam logic [7:0]  SZ_CODE  = 8'(FLASH_LOG2 - 1);
  localparam logic [15:0] NBLK_M1  = 16'(NBLK - 1);
  localparam logic [15:0] BLK_U256 = 16'((1 << (BLK_LOG2 - 1)) / 256);
  localparam logic [7:0]  BUF_CODE = 8'(PBUF_LOG2 - 1);

  function automatic logic [7:0] query_byte(input logic [QI_W-1:0] idx);
    logic [7:0] b;
    b = 8'h00;
    if (idx <= QI_W'(8'hFF)) begin
      case (idx[7:0])
        8'h10: b = 8'h51;
        8'h11: b = 8'h52;
        8'h12: b = 8'h59;
        8'h13: b = 8'h01;
        8'h15: b = 8'h31;
        8'h1b: b = 8'h45;
        8'h1c: b = 8'h55;
        8'h1f: b = 8'h01;
        8'h20: b = 8'h01;
        8'h21: b = 8'h01;
        8'h27: b = SZ_CODE;
        8'h28: b = 8'h05;
        8'h2a: b = BUF_CODE;
        8'h2c: b = 8'h01;
        8'h2d: b = NBLK_M1[7:0];
        8'h2e: b = NBLK_M1[15:8];
        8'h2f: b = BLK_U256[7:0];
        8'h30: b = BLK_U256[15:8];
        8'h31: b = 8'h50;
        8'h32: b = 8'h52;
        8'h33: b = 8'h49;
        8'h34: b = 8'h31;
        8'h35: b = 8'h30;
        8'h36: b = 8'ha0;
        8'h3b: b = 8'h01;
        8'h3d: b = 8'h50;
        8'h3f: b = 8'h01;
        default: b = 8'h00;
      endcase
    end
    return b;
  endfunction

  logic [QI_W-1:0]               q_idx;
  logic [8:0]                    id_idx;
  logic [FLASH_LOG2-BLK_LOG2-1:0] blk_idx;
  logic [15:0]                   v16;
  logic [63:0]                   lane;
  logic [63:0]                   nxt;

  assign q_idx   = rd_addr[FLASH_LOG2-1:2];
  assign id_idx  = rd_addr[10:2];
  assign blk_idx = rd_addr[FLASH_LOG2-1:BLK_LOG2];

  always_comb begin
    case (rd_mode)
      2'd1:    v16 = {8'h00, status_reg};
      2'd2: begin
        case (id_idx)
          9'd0:    v16 = 16'h0000;
          9'd1:    v16 = 16'hFFFF;
          9'd2:    v16 = {15'h0, lock_map[blk_idx]};
          default: v16 = 16'h0000;
        endcase
      end
      2'd3:    v16 = {8'h00, query_byte(q_idx)};
      default: v16 = 16'h0000;
    endcase
  end

  always_comb begin
    case (rd_size)
      2'd0:    lane = {56'h0, 8'(array_word >> {rd_addr[2:0], 3'b000})};
      2'd1:    lane = {48'h0, 16'(array_word >> {rd_addr[2:1], 4'b0000})};
      2'd2:    lane = {32'h0, 32'(array_word >> {rd_addr[2], 5'b00000})};
      default: lane = array_word;
    endcase
  end

  always_comb begin
    if (rd_mode == 2'd0) nxt = lane;
    else begin
      case (rd_size)
        2'd0:    nxt = {56'h0, v16[7:0]};
        2'd1:    nxt = {48'h0, v16};
        default: nxt = {32'h0, v16, v16};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= 64'h0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= nxt;
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  p_mirror_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_mode != 2'd0 && rd_size[1]) |=>
      (rd_data[31:16] == rd_data[15:0] && rd_data[63:32] == 32'h0));
  p_byte_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_size == 2'd0) |=> (rd_data[63:8] == 56'h0));
  p_status_zext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_mode == 2'd1 && rd_size == 2'd1) |=> (rd_data[63:8] == 56'h0));
endmodule

// File: tb/sim_flash_read_mux.sv
module sim_flash_read_mux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic [19:0] rd_addr = '0;
  logic [1:0]  rd_size = '0;
  logic [1:0]  rd_mode = '0;
  logic [7:0]  status_reg = 8'h80;
  logic [15:0] lock_map = '0;
  logic [63:0] array_word = '0;
  logic [63:0] rd_data;
  logic        rd_valid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  flash_read_mux u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_size(rd_size), .rd_mode(rd_mode), .status_reg(status_reg),
    .lock_map(lock_map), .array_word(array_word),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #5 clk = ~clk;

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d cycles, expected completion", cyc);
      report();
    end
  end

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input string req, input logic [19:0] a, input logic [1:0] sz,
                    input logic [1:0] md, input logic [63:0] exp);
    @(negedge clk);
    rd_addr = a; rd_size = sz; rd_mode = md; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check({req, " valid"}, {63'h0, rd_valid}, 64'h1);
    check(req, rd_data, exp);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1 reset data", rd_data, 64'h0);
    check("R1 reset valid", {63'h0, rd_valid}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release data", rd_data, 64'h0);
    check("R1 after release valid", {63'h0, rd_valid}, 64'h0);
  endtask

  task automatic t_array;
    array_word = 64'hF0E1D2C3B4A59687;
    rd("R3 byte lane 5", 20'h00005, 2'd0, 2'd0, 64'h00000000000000D2);
    rd("R3 byte lane 0", 20'h01238, 2'd0, 2'd0, 64'h0000000000000087);
    rd("R3 half lanes 6-7", 20'h00006, 2'd1, 2'd0, 64'h000000000000F0E1);
    rd("R3 half lanes 2-3", 20'h00002, 2'd1, 2'd0, 64'h000000000000B4A5);
    rd("R3 word upper", 20'h00004, 2'd2, 2'd0, 64'h00000000F0E1D2C3);
    rd("R3 double", 20'h00000, 2'd3, 2'd0, 64'hF0E1D2C3B4A59687);
  endtask

  task automatic t_status;
    status_reg = 8'h80;
    rd("R4 status 2B", 20'h00000, 2'd1, 2'd1, 64'h0000000000000080);
    rd("R10 status 4B mirror", 20'h00010, 2'd2, 2'd1, 64'h0000000000800080);
    status_reg = 8'hB2;
    rd("R10 status 8B upper clear", 20'h00000, 2'd3, 2'd1, 64'h0000000000B200B2);
    rd("R10 status 1B", 20'h00000, 2'd0, 2'd1, 64'h00000000000000B2);
  endtask

  task automatic t_devid;
    lock_map = 16'h0020;
    rd("R5 vendor", 20'h00000, 2'd1, 2'd2, 64'h0);
    rd("R5 device", 20'h00004, 2'd1, 2'd2, 64'h000000000000FFFF);
    rd("R10 device 4B mirror", 20'h00004, 2'd2, 2'd2, 64'h00000000FFFFFFFF);
    rd("R5 device above mask", 20'h30804, 2'd1, 2'd2, 64'h000000000000FFFF);
    rd("R5 index 3 zero", 20'h0000C, 2'd1, 2'd2, 64'h0);
    rd("R5 high index zero", 20'h507F8, 2'd1, 2'd2, 64'h0);
    rd("R6 locked block 5", 20'h50008, 2'd1, 2'd2, 64'h1);
    rd("R6 unlocked block 4", 20'h40008, 2'd1, 2'd2, 64'h0);
    rd("R6 unlocked block 6", 20'h60808, 2'd1, 2'd2, 64'h0);
  endtask

  task automatic t_query;
    rd("R7 Q", 20'h00040, 2'd0, 2'd3, 64'h51);
    rd("R7 Q low bits ignored", 20'h00043, 2'd0, 2'd3, 64'h51);
    rd("R7 R", 20'h00044, 2'd0, 2'd3, 64'h52);
    rd("R7 Y", 20'h00048, 2'd0, 2'd3, 64'h59);
    rd("R7 cmd set", 20'h0004C, 2'd1, 2'd3, 64'h01);
    rd("R7 ext table addr", 20'h00054, 2'd1, 2'd3, 64'h31);
    rd("R7 P", 20'h000C4, 2'd1, 2'd3, 64'h50);
    rd("R7 I", 20'h000CC, 2'd1, 2'd3, 64'h49);
    rd("R10 query 4B mirror", 20'h00040, 2'd2, 2'd3, 64'h0000000000510051);
    rd("R8 size code", 20'h0009C, 2'd1, 2'd3, 64'h13);
    rd("R8 block count lo", 20'h000B4, 2'd1, 2'd3, 64'h0F);
    rd("R8 block count hi", 20'h000B8, 2'd1, 2'd3, 64'h00);
    rd("R8 block size lo", 20'h000BC, 2'd1, 2'd3, 64'h80);
    rd("R8 block size hi", 20'h000C0, 2'd1, 2'd3, 64'h00);
    rd("R9 first past table", 20'h00110, 2'd1, 2'd3, 64'h0);
    rd("R9 far index", 20'h10040, 2'd2, 2'd3, 64'h0);
  endtask

  task automatic t_hold;
    logic [63:0] held;
    rd("R2 setup read", 20'h00040, 2'd2, 2'd3, 64'h0000000000510051);
    held = rd_data;
    @(negedge clk);
    rd_mode = 2'd0; rd_addr = 20'h00005; array_word = 64'h1;
    check("R2 valid low after idle", {63'h0, rd_valid}, 64'h0);
    repeat (3) @(negedge clk);
    check("R2 data held while idle", rd_data, held);
    check("R2 valid stays low", {63'h0, rd_valid}, 64'h0);
  endtask

  initial begin
    t_reset();
    t_array();
    t_status();
    t_devid();
    t_query();
    t_hold();
    report();
  end
endmodule